// File: doc/BRIEF.md
# Sticky Transfer Error Status Unit

This unit sits between the serial-memory target and the interconnect that serves its data. It watches three kinds of trouble on each transfer. A read word may arrive too late: either it is not there when the latency window closes, or the next word of a burst is not there when the last bit of the current word goes out on the wire. A host may push write words faster than the interconnect drains them. The interconnect may also answer with an error response. Each kind of trouble sets a bit or field in one status word. That word stays set until the host reads it, and the read clears it.

A single control bit enables an interrupt line, which is high while that bit is set and the status word is non-zero. A write-in-progress flag lets the host poll until a write it has sent over the wire is finished on the interconnect side. The host is expected to poll the flag, read the status word, and start recovery if the word is non-zero.

Top module: `xfer_err_status`

## Requirements
- R1: After synchronous reset the status word, the interrupt enable, the interrupt line and the write-in-progress flag are all zero.
- R2: A latency-end pulse while no read word is available sets the underflow bit (status bit 0). The same pulse with a word available sets nothing.
- R3: A word-end pulse while more burst words remain and no next word is available sets the underflow bit. It sets nothing if the burst has no more words or if the next word is available.
- R4: The write holding stage keeps up to DEPTH words (default 2). A push while it is full and no word is consumed in the same cycle sets the overflow bit (status bit 1). A push with a same-cycle consume does not set it.
- R5: The response field (status bits 3:2) takes the code of each valid response whose code is non-zero, so the newest error code replaces an older one. A valid response with code 00 changes nothing, and 00 in the field means no error recorded.
- R6: Status bits stay set across idle cycles. A status read returns the word held before the clear, and from the next cycle the word is zero.
- R7: An error event in the same cycle as a status read leaves its bit or code set after the clear.
- R8: The interrupt line is high exactly when the enable bit is set and the status word is non-zero.
- R9: The enable bit takes the control write data on a control write strobe and keeps its value otherwise.
- R10: A write-frame-end pulse sets write-in-progress and a write-done pulse clears it. When both arrive in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_end | input | 1 | Pulse: the read latency window closes this cycle |
| word_end | input | 1 | Pulse: the last bit of the current read word leaves the wire |
| burst_more | input | 1 | More read words remain in the current burst |
| rd_avail | input | 1 | The next read word is available from the interconnect |
| wr_push | input | 1 | The host presents a write word |
| wr_pop | input | 1 | The interconnect consumes a write word |
| resp_valid | input | 1 | An interconnect response is presented |
| resp_code | input | 2 | Response code, 00 = OK |
| stat_rd | input | 1 | Status read strobe, which clears the status word |
| stat_rdata | output | 4 | Status word {resp[1:0], overflow, underflow} |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 1 | Interrupt enable value to write |
| irq_en | output | 1 | Current interrupt enable |
| irq | output | 1 | Interrupt request |
| wr_frame_end | input | 1 | Pulse: a write frame has ended on the wire |
| wr_done | input | 1 | Pulse: the interconnect has finished the write |
| wip | output | 1 | Write in progress |

## Verification
The embedded properties check on every cycle that status bits hold while no read occurs, that a read with no new event empties the word, that a same-cycle event survives the clear, that the holding count never passes its depth, that the interrupt never rises with the word empty or the enable off, and that a frame end always leaves the flag set. Only the bench's scenarios can show which input combinations count as underflow or overflow and which do not. The same goes for the response field keeping the newest non-zero code while ignoring OK responses, and for the read returning the value held before the clear.

// File: rtl/xes_pkg.sv
package xes_pkg;

    localparam int RESP_W = 2;
    localparam int STAT_W = RESP_W + 2;

    typedef enum logic [RESP_W-1:0] {
        RESP_OK   = 2'b00,
        RESP_EXOK = 2'b01,
        RESP_SLV  = 2'b10,
        RESP_DEC  = 2'b11
    } resp_e;

    typedef struct packed {
        logic [RESP_W-1:0] resp;
        logic              ovf;
        logic              udf;
    } stat_t;

    typedef struct packed {
        logic              udf;
        logic              ovf;
        logic              resp_hit;
        logic [RESP_W-1:0] resp;
    } evt_t;

    function automatic logic stat_nonzero(stat_t s);
        return (s.udf | s.ovf | (s.resp != RESP_OK));
    endfunction

    function automatic logic resp_is_err(logic vld, logic [RESP_W-1:0] code);
        return vld && (code != RESP_OK);
    endfunction

endpackage

// File: rtl/xes_rd_underflow.sv
module xes_rd_underflow (
    input  logic lat_end,
    input  logic word_end,
    input  logic burst_more,
    input  logic rd_avail,
    output logic udf_evt
);
    logic late_first;
    logic late_next;

    always_comb begin
        late_first = lat_end && !rd_avail;
        late_next  = word_end && burst_more && !rd_avail;
        udf_evt    = late_first || late_next;
    end
endmodule

// File: rtl/xes_wr_overflow.sv
module xes_wr_overflow #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_push,
    input  logic wr_pop,
    output logic ovf_evt
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] count_q;
    logic          is_full;
    logic          is_empty;
    logic          do_inc;
    logic          do_dec;

    always_comb begin
        is_full  = (count_q == FULL);
        is_empty = (count_q == '0);
        do_dec   = wr_pop && !is_empty;
        do_inc   = wr_push && (!is_full || do_dec);
        ovf_evt  = wr_push && is_full && !do_dec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (do_inc && !do_dec) begin
            count_q <= count_q + 1'b1;
        end else if (do_dec && !do_inc) begin
            count_q <= count_q - 1'b1;
        end
    end

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= FULL);

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (is_full && wr_push && !wr_pop) |=> is_full);
endmodule

// File: rtl/xes_sticky.sv
module xes_sticky
    import xes_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  evt_t              evt,
    input  logic              clr,
    output stat_t             stat
);
    stat_t stat_q;
    stat_t stat_d;

    always_comb begin
        stat_d = clr ? '0 : stat_q;
        if (evt.udf)      stat_d.udf  = 1'b1;
        if (evt.ovf)      stat_d.ovf  = 1'b1;
        if (evt.resp_hit) stat_d.resp = evt.resp;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assign stat = stat_q;

    // R6
    udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q.udf && !clr) |=> stat_q.udf);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q.ovf && !clr) |=> stat_q.ovf);

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt.udf && !evt.ovf && !evt.resp_hit) |=> (stat_q == '0));

    // R7
    udf_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && evt.udf) |=> stat_q.udf);

    // R7
    ovf_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && evt.ovf) |=> stat_q.ovf);

    // R5
    resp_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        evt.resp_hit |=> (stat_q.resp != RESP_OK));
endmodule

// File: rtl/xes_wip.sv
module xes_wip (
    input  logic clk,
    input  logic rst,
    input  logic frame_end,
    input  logic done,
    output logic wip
);
    logic wip_q;

    always_ff @(posedge clk) begin
        if (rst)            wip_q <= 1'b0;
        else if (frame_end) wip_q <= 1'b1;
        else if (done)      wip_q <= 1'b0;
    end

    assign wip = wip_q;

    // R10
    wip_set_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> wip_q);

    // R10
    wip_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !frame_end) |=> !wip_q);
endmodule

// File: rtl/xfer_err_status.sv
module xfer_err_status
    import xes_pkg::*;
#(
    parameter int WR_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lat_end,
    input  logic              word_end,
    input  logic              burst_more,
    input  logic              rd_avail,
    input  logic              wr_push,
    input  logic              wr_pop,
    input  logic              resp_valid,
    input  logic [RESP_W-1:0] resp_code,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_rdata,
    input  logic              ctl_wr,
    input  logic              ctl_wdata,
    output logic              irq_en,
    output logic              irq,
    input  logic              wr_frame_end,
    input  logic              wr_done,
    output logic              wip
);
    evt_t  evt;
    stat_t stat;
    logic  udf_evt;
    logic  ovf_evt;
    logic  en_q;

    xes_rd_underflow u_udf (
        .lat_end    (lat_end),
        .word_end   (word_end),
        .burst_more (burst_more),
        .rd_avail   (rd_avail),
        .udf_evt    (udf_evt)
    );

    xes_wr_overflow #(.DEPTH(WR_DEPTH)) u_ovf (
        .clk     (clk),
        .rst     (rst),
        .wr_push (wr_push),
        .wr_pop  (wr_pop),
        .ovf_evt (ovf_evt)
    );

    always_comb begin
        evt.udf      = udf_evt;
        evt.ovf      = ovf_evt;
        evt.resp_hit = resp_is_err(resp_valid, resp_code);
        evt.resp     = resp_code;
    end

    xes_sticky u_stk (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .clr  (stat_rd),
        .stat (stat)
    );

    always_ff @(posedge clk) begin
        if (rst)         en_q <= 1'b0;
        else if (ctl_wr) en_q <= ctl_wdata;
    end

    xes_wip u_wip (
        .clk       (clk),
        .rst       (rst),
        .frame_end (wr_frame_end),
        .done      (wr_done),
        .wip       (wip)
    );

    assign stat_rdata = stat;
    assign irq_en     = en_q;
    assign irq        = en_q && stat_nonzero(stat);

    // R8
    irq_needs_stat_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_rdata != '0));

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> irq_en);

    // R9
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> $stable(irq_en));
endmodule

// File: tb/sim_xfer_err_status.sv
module sim_xfer_err_status;
    logic       clk = 1'b0;
    logic       rst;
    logic       lat_end, word_end, burst_more, rd_avail;
    logic       wr_push, wr_pop, resp_valid;
    logic [1:0] resp_code;
    logic       stat_rd;
    logic [3:0] stat_rdata;
    logic       ctl_wr, ctl_wdata, irq_en, irq;
    logic       wr_frame_end, wr_done, wip;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    xfer_err_status u0 (
        .clk(clk), .rst(rst), .lat_end(lat_end), .word_end(word_end),
        .burst_more(burst_more), .rd_avail(rd_avail), .wr_push(wr_push),
        .wr_pop(wr_pop), .resp_valid(resp_valid), .resp_code(resp_code),
        .stat_rd(stat_rd), .stat_rdata(stat_rdata), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .irq_en(irq_en), .irq(irq),
        .wr_frame_end(wr_frame_end), .wr_done(wr_done), .wip(wip)
    );

    // vector: {lat_end, word_end, burst_more, rd_avail, resp_valid, resp[1:0], exp[3:0]}
    localparam int NV = 10;
    localparam logic [10:0] VEC [NV] = '{
        {4'b1000, 3'b000, 4'b0001},  // R2 latency end, no data
        {4'b1001, 3'b000, 4'b0000},  // R2 latency end, data present
        {4'b0110, 3'b000, 4'b0001},  // R3 word end, more, no data
        {4'b0111, 3'b000, 4'b0000},  // R3 next word ready
        {4'b0100, 3'b000, 4'b0000},  // R3 burst over
        {4'b0000, 3'b110, 4'b1000},  // R5 code 10
        {4'b0000, 3'b111, 4'b1100},  // R5 code 11
        {4'b0000, 3'b101, 4'b0100},  // R5 code 01
        {4'b0000, 3'b100, 4'b0000},  // R5 OK ignored
        {4'b1110, 3'b111, 4'b1101}   // R2 R3 R5 combined
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        lat_end = 0; word_end = 0; burst_more = 0; rd_avail = 0;
        wr_push = 0; wr_pop = 0; resp_valid = 0; resp_code = 2'b00;
        stat_rd = 0; ctl_wr = 0; ctl_wdata = 0; wr_frame_end = 0; wr_done = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic clear_stat();
        stat_rd = 1;
        tick();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 status", stat_rdata, 4'h0);
        chk("R1 flags", {1'b0, irq_en, irq, wip}, 4'h0);

        for (int i = 0; i < NV; i++) begin
            {lat_end, word_end, burst_more, rd_avail} = VEC[i][10:7];
            resp_valid = VEC[i][6];
            resp_code  = VEC[i][5:4];
            tick();
            tick();
            chk($sformatf("R2/R3/R5 vec%0d", i), stat_rdata, VEC[i][3:0]);
            clear_stat();
        end

        // R5 newest non-zero code wins, OK does not erase
        resp_valid = 1; resp_code = 2'b10; tick();
        resp_valid = 1; resp_code = 2'b01; tick();
        resp_valid = 1; resp_code = 2'b00; tick();
        chk("R5 newest kept", stat_rdata, 4'b0100);
        clear_stat();

        // R4 overflow: fill two, third push without pop
        wr_push = 1; tick();
        wr_push = 1; tick();
        chk("R4 no ovf until full", stat_rdata, 4'h0);
        wr_push = 1; wr_pop = 1; tick();
        chk("R4 push+pop at full", stat_rdata, 4'h0);
        wr_push = 1; tick();
        chk("R4 ovf", stat_rdata, 4'b0010);
        wr_pop = 1; tick();
        wr_pop = 1; tick();
        clear_stat();

        // R6 sticky over idle, read returns held value, then zero
        lat_end = 1; tick();
        repeat (5) tick();
        chk("R6 sticky", stat_rdata, 4'b0001);
        stat_rd = 1;
        #1;
        chk("R6 read value", stat_rdata, 4'b0001);
        tick();
        chk("R6 cleared", stat_rdata, 4'h0);

        // R7 event same cycle as read
        lat_end = 1; tick();
        stat_rd = 1; word_end = 1; burst_more = 1; resp_valid = 1; resp_code = 2'b11;
        tick();
        chk("R7 kept", stat_rdata, 4'b1101);
        clear_stat();
        chk("R7 then clear", stat_rdata, 4'h0);

        // R9 / R8 enable and interrupt
        lat_end = 1; tick();
        chk("R8 irq off when disabled", {3'b0, irq}, 4'h0);
        ctl_wr = 1; ctl_wdata = 1; tick();
        chk("R9 enable written", {3'b0, irq_en}, 4'h1);
        chk("R8 irq on", {3'b0, irq}, 4'h1);
        repeat (2) tick();
        chk("R9 enable held", {3'b0, irq_en}, 4'h1);
        clear_stat();
        chk("R8 irq off when clear", {3'b0, irq}, 4'h0);
        ctl_wr = 1; ctl_wdata = 0; tick();
        chk("R9 enable cleared", {3'b0, irq_en}, 4'h0);

        // R10 write in progress
        wr_frame_end = 1; tick();
        repeat (3) tick();
        chk("R10 wip set", {3'b0, wip}, 4'h1);
        wr_done = 1; tick();
        chk("R10 wip cleared", {3'b0, wip}, 4'h0);
        wr_frame_end = 1; wr_done = 1; tick();
        chk("R10 set wins", {3'b0, wip}, 4'h1);

        // R1 reset again from busy state
        lat_end = 1; ctl_wr = 1; ctl_wdata = 1; tick();
        rst = 1; tick(); rst = 0;
        chk("R1 reset status", stat_rdata, 4'h0);
        chk("R1 reset flags", {1'b0, irq_en, irq, wip}, 4'h0);

        finish_run();
    end
endmodule